// File: doc/BRIEF.md
# Data-Strobe Serial Link Transmitter

This block turns a stream of video words into a two-wire serial signal for a short chip-to-chip hop. In every word period it collects, for each of its parallel links, four video samples, two audio bits and a per-link valid flag. It builds a fixed-format word from them, with a two-bit alignment marker at the front, and shifts that word out one bit per bit-clock cycle. The bit clock runs at the word rate times the word length. With the default 44-bit word at 13.5 MHz this gives 594 Mbit/s per link.

Each link drives two lines. The data line carries the bit value. The strobe line changes in every bit period where the data line does not, so the exclusive-OR of the two lines changes once per bit. A receiver can recover bit timing from that edge without a clock wire, and it can find word boundaries from the fixed marker. A shared word timer raises `word_load` for one bit-clock cycle in every word period. The source must present the next word's contents during that cycle. A link whose valid flag is low at that moment sends an all-zero payload behind an intact marker. Differential drivers and clock multiplication are outside this block.

Top module: `ds_link_tx`

## Requirements
- R1: While reset is active, and until the first word has been loaded, every `ser_data` and `ser_strobe` bit is low.
- R2: `word_load` is high in the first bit-clock cycle after reset is released. After that it is high for exactly one cycle in every 44 cycles.
- R3: The word is sent in this order: the marker bits 1 then 0, then sample 0, sample 1, sample 2 and sample 3, each most-significant bit first, then audio bit 1 and audio bit 0. Sample j of link l is taken from `samples[(l*4+j)*10 +: 10]`, and the audio pair of link l from `audio[l*2 +: 2]`.
- R4: The first marker bit appears on `ser_data` in the cycle after the `word_load` cycle. Each later bit follows in the next cycle.
- R5: Once a word has been loaded, in every cycle at least one of `ser_data` and `ser_strobe` of each link differs from its value in the previous cycle.
- R6: `ser_data` and `ser_strobe` of a link never both change in the same cycle. The strobe holds when the data changes and toggles when the data repeats.
- R7: If a link's `word_valid` bit is low during the `word_load` cycle, that link sends the marker 1,0 followed by 42 zero bits. The audio bits are zero as well.
- R8: Inputs are sampled only at the clock edge that ends a `word_load` cycle. Changes at any other time do not alter the word being sent.
- R9: Each link uses only its own valid bit, samples and audio bits.
- R10: Words follow each other with no gap. The last audio bit of one word is on the line in the same cycle that `word_load` is high for the next word, and the next marker bit follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 44 times the word rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 3 | Per-link flag: the word inputs hold a real word |
| samples | input | 120 | Four 10-bit samples per link, link-major |
| audio | input | 6 | Two audio bits per link |
| word_load | output | 1 | High in the cycle whose closing edge latches the inputs |
| ser_data | output | 3 | Serial data line, one per link |
| ser_strobe | output | 3 | Serial strobe line, one per link |

## Verification
Two things happen at the same clock edge: the last audio bit of a word goes onto the line, and the next word is latched. The strobe rule must therefore carry across the boundary, from the last bit of the old word into the first marker bit of the new one. The bench sends two words back to back with different contents. It checks that `word_load` is high in the cycle where the final bit of the first word is on the line. It then decodes the second word in full and counts any cycle where the data/strobe pair fails to make exactly one transition. A second overlap comes from changing inputs in the middle of a word. The words on the line must not change as a result.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

   // Line state of one link: the two wires driven off chip.
   typedef struct packed {
      logic data;
      logic strobe;
   } ds_line_t;

   // Next line state: data follows the bit, strobe flips only when data repeats.
   function automatic ds_line_t ds_encode(ds_line_t cur, logic bit_in);
      ds_line_t nxt;
      nxt.data   = bit_in;
      nxt.strobe = (bit_in == cur.data) ? ~cur.strobe : cur.strobe;
      return nxt;
   endfunction

   function automatic int ds_word_bits(int sync_w, int n_smp, int smp_w, int aud_w);
      return sync_w + n_smp * smp_w + aud_w;
   endfunction

endpackage

// File: rtl/ds_bit_timer.sv
module ds_bit_timer #(
   parameter int WORD_W = 44
) (
   input  logic clk,
   input  logic rst_n,
   output logic word_load
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign word_load = (cnt_q == '0);
endmodule

// File: rtl/ds_word_pack.sv
module ds_word_pack #(
   parameter int NUM_SAMPLES = 4,
   parameter int SAMPLE_W    = 10,
   parameter int AUDIO_W     = 2,
   parameter int SYNC_W      = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b10,
   parameter int WORD_W      = 44
) (
   input  logic                            valid,
   input  logic [NUM_SAMPLES*SAMPLE_W-1:0] samples,
   input  logic [AUDIO_W-1:0]              audio,
   output logic [WORD_W-1:0]               word
);
   localparam int PAY_W = WORD_W - SYNC_W;

   if (PAY_W != NUM_SAMPLES * SAMPLE_W + AUDIO_W) begin : g_bad_width
      $error("ds_word_pack: WORD_W does not match its fields");
   end

   logic [PAY_W-1:0] payload;

   // Sample 0 sits next to the marker; the audio pair closes the word.
   for (genvar j = 0; j < NUM_SAMPLES; j++) begin : g_smp
      assign payload[PAY_W-1-j*SAMPLE_W -: SAMPLE_W] = samples[j*SAMPLE_W +: SAMPLE_W];
   end
   assign payload[AUDIO_W-1:0] = audio;

   assign word = {SYNC_PAT, valid ? payload : {PAY_W{1'b0}}};
endmodule

// File: rtl/ds_serializer.sv
module ds_serializer
   import ds_link_pkg::*;
#(
   parameter int WORD_W = 44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic              ser_data,
   output logic              ser_strobe
);
   logic [WORD_W-1:0] shreg;
   ds_line_t          line_q;
   logic              run_q;
   logic              next_bit;

   // On a load edge the first bit goes straight to the line and the rest is stored.
   assign next_bit = load ? word_in[WORD_W-1] : shreg[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         line_q <= '0;
         run_q  <= 1'b0;
      end else if (load) begin
         shreg  <= {word_in[WORD_W-2:0], 1'b0};
         line_q <= ds_encode(line_q, next_bit);
         run_q  <= 1'b1;
      end else if (run_q) begin
         shreg  <= {shreg[WORD_W-2:0], 1'b0};
         line_q <= ds_encode(line_q, next_bit);
      end
   end

   assign ser_data   = line_q.data;
   assign ser_strobe = line_q.strobe;
endmodule

// File: rtl/ds_link_tx.sv
module ds_link_tx
   import ds_link_pkg::*;
#(
   parameter int NUM_LINKS   = 3,
   parameter int NUM_SAMPLES = 4,
   parameter int SAMPLE_W    = 10,
   parameter int AUDIO_W     = 2,
   parameter int SYNC_W      = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b10
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [NUM_LINKS-1:0]                      word_valid,
   input  logic [NUM_LINKS*NUM_SAMPLES*SAMPLE_W-1:0] samples,
   input  logic [NUM_LINKS*AUDIO_W-1:0]              audio,
   output logic                                      word_load,
   output logic [NUM_LINKS-1:0]                      ser_data,
   output logic [NUM_LINKS-1:0]                      ser_strobe
);
   localparam int WORD_W  = ds_word_bits(SYNC_W, NUM_SAMPLES, SAMPLE_W, AUDIO_W);
   localparam int LSMP_W  = NUM_SAMPLES * SAMPLE_W;

   if (NUM_LINKS < 1) begin : g_bad_links
      $error("ds_link_tx: NUM_LINKS must be at least 1");
   end
   if (SYNC_W < 2) begin : g_bad_sync
      $error("ds_link_tx: SYNC_W must be at least 2");
   end
   if (SYNC_PAT[SYNC_W-1] == SYNC_PAT[SYNC_W-2]) begin : g_bad_pat
      $error("ds_link_tx: marker must start with an edge");
   end

   ds_bit_timer #(.WORD_W(WORD_W)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_load (word_load)
   );

   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
      logic [WORD_W-1:0] word;

      ds_word_pack #(
         .NUM_SAMPLES (NUM_SAMPLES),
         .SAMPLE_W    (SAMPLE_W),
         .AUDIO_W     (AUDIO_W),
         .SYNC_W      (SYNC_W),
         .SYNC_PAT    (SYNC_PAT),
         .WORD_W      (WORD_W)
      ) i_pack (
         .valid   (word_valid[l]),
         .samples (samples[l*LSMP_W +: LSMP_W]),
         .audio   (audio[l*AUDIO_W +: AUDIO_W]),
         .word    (word)
      );

      ds_serializer #(.WORD_W(WORD_W)) i_ser (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (word_load),
         .word_in    (word),
         .ser_data   (ser_data[l]),
         .ser_strobe (ser_strobe[l])
      );
   end
endmodule

// File: rtl/ds_link_tx_chk.sv
module ds_link_tx_chk #(
   parameter int NUM_LINKS = 3,
   parameter int WORD_W    = 44,
   parameter int SYNC_W    = 2,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 word_load,
   input logic [NUM_LINKS-1:0] ser_data,
   input logic [NUM_LINKS-1:0] ser_strobe
);
   localparam int GAP_W = $clog2(WORD_W) + 2;

   logic                 run_q, seen_q, wl_d1, wl_d2;
   logic [NUM_LINKS-1:0] pd_q, ps_q;
   logic [GAP_W-1:0]     gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; seen_q <= 1'b0; wl_d1 <= 1'b0; wl_d2 <= 1'b0;
         pd_q  <= '0;   ps_q   <= '0;   gap_q <= '0;
      end else begin
         wl_d1 <= word_load;
         wl_d2 <= wl_d1;
         pd_q  <= ser_data;
         ps_q  <= ser_strobe;
         if (word_load) begin
            run_q  <= 1'b1;
            seen_q <= 1'b1;
            gap_q  <= '0;
         end else begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   // R1: lines stay quiet until the first word is on its way
   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (ser_data == '0 && ser_strobe == '0));

   // R2: one load every WORD_W cycles
   p_load_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && word_load) |-> gap_q == GAP_W'(WORD_W - 1));
   p_load_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !word_load) |-> gap_q < GAP_W'(WORD_W - 1));

   // R5: some wire of each link moves every bit
   p_bit_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> ((ser_data ^ pd_q) | (ser_strobe ^ ps_q)) == '1);

   // R6: never both wires at once
   p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> ((ser_data ^ pd_q) & (ser_strobe ^ ps_q)) == '0);

   // R7 (and R3, R4): marker leads every word on every link
   p_marker_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wl_d1 |-> ser_data == {NUM_LINKS{SYNC_PAT[SYNC_W-1]}});
   p_marker_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wl_d2 |-> ser_data == {NUM_LINKS{SYNC_PAT[SYNC_W-2]}});
endmodule

bind ds_link_tx ds_link_tx_chk #(
   .NUM_LINKS (NUM_LINKS),
   .WORD_W    (WORD_W),
   .SYNC_W    (SYNC_W),
   .SYNC_PAT  (SYNC_PAT)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_load  (word_load),
   .ser_data   (ser_data),
   .ser_strobe (ser_strobe)
);

// File: tb/test_ds_link_tx.sv
module test_ds_link_tx;
   localparam int NL = 3;
   localparam int NS = 4;
   localparam int SW = 10;
   localparam int AW = 2;
   localparam int WW = 44;
   localparam int LS = NS * SW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NL-1:0]     valid_r = '0;
   logic [NL*LS-1:0]  smp_r = '0;
   logic [NL*AW-1:0]  aud_r = '0;
   logic              word_load;
   logic [NL-1:0]     ser_data, ser_strobe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ds_link_tx i_ds_link_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (valid_r),
      .samples    (smp_r),
      .audio      (aud_r),
      .word_load  (word_load),
      .ser_data   (ser_data),
      .ser_strobe (ser_strobe)
   );

   // Expected word from R3/R7: marker 1,0; samples 0..3 MSB first; audio 1,0.
   function automatic logic [WW-1:0] exp_word(logic v, logic [LS-1:0] s, logic [AW-1:0] a);
      logic [WW-1:0] w;
      w = '0;
      w[WW-1] = 1'b1;
      if (v) begin
         for (int j = 0; j < NS; j++)
            for (int b = 0; b < SW; b++)
               w[WW-3-j*SW-b] = s[j*SW + SW-1-b];
         w[1] = a[1];
         w[0] = a[0];
      end
      return w;
   endfunction

   task automatic check_val(string req, string what, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic set_link(int l, logic v, logic [SW-1:0] s0, logic [SW-1:0] s1,
                           logic [SW-1:0] s2, logic [SW-1:0] s3, logic [AW-1:0] a);
      valid_r[l] = v;
      smp_r[l*LS +: LS] = {s3, s2, s1, s0};
      aud_r[l*AW +: AW] = a;
   endtask

   // Receiver: waits for a load cycle, decodes one word per link, checks the line rule.
   task automatic capture(string req, bit scramble);
      logic [WW-1:0] ex [NL];
      logic [WW-1:0] got [NL];
      int            bad [NL];
      logic [NL-1:0] pd, ps;
      while (!word_load) @(negedge clk);
      for (int l = 0; l < NL; l++) begin
         ex[l]  = exp_word(valid_r[l], smp_r[l*LS +: LS], aud_r[l*AW +: AW]);
         got[l] = '0;
         bad[l] = 0;
      end
      pd = ser_data;
      ps = ser_strobe;
      for (int k = 0; k < WW; k++) begin
         @(negedge clk);
         if (scramble && k == 5) begin
            smp_r = ~smp_r;
            aud_r = ~aud_r;
         end
         for (int l = 0; l < NL; l++) begin
            got[l][WW-1-k] = ser_data[l];
            if (((ser_data[l] ^ pd[l]) ^ (ser_strobe[l] ^ ps[l])) !== 1'b1) bad[l]++;
         end
         pd = ser_data;
         ps = ser_strobe;
      end
      for (int l = 0; l < NL; l++) begin
         check_val(req, $sformatf("word link%0d", l), 64'(got[l]), 64'(ex[l]));
         check_val("R5 R6", $sformatf("line rule misses link%0d", l), 64'(bad[l]), 64'd0);
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check_val("R1", "lines in reset", 64'({ser_data, ser_strobe}), 64'd0);
      rst_n = 1'b1;
      #1;
      check_val("R2", "load after release", 64'(word_load), 64'd1);
      check_val("R1", "lines before first load", 64'({ser_data, ser_strobe}), 64'd0);
   endtask

   task automatic t_period;
      int n;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!word_load && n < 200);
      check_val("R2", "load spacing", 64'(n), 64'(WW));
   endtask

   task automatic t_invalid_all;
      for (int l = 0; l < NL; l++) set_link(l, 1'b0, 10'h3FF, 10'h155, 10'h2AA, 10'h3FF, 2'b11);
      capture("R7", 1'b0);
   endtask

   task automatic t_pattern_a;
      set_link(0, 1'b1, 10'h3FF, 10'h000, 10'h2AA, 10'h155, 2'b01);
      set_link(1, 1'b1, 10'h123, 10'h0F0, 10'h30C, 10'h001, 2'b10);
      set_link(2, 1'b1, 10'h200, 10'h001, 10'h3FE, 10'h1C7, 2'b11);
      capture("R3 R4 R9", 1'b0);
   endtask

   task automatic t_zero_payload;
      for (int l = 0; l < NL; l++) set_link(l, 1'b1, 10'h000, 10'h000, 10'h000, 10'h000, 2'b00);
      capture("R3 R6", 1'b0);
   endtask

   task automatic t_mixed_valid;
      set_link(0, 1'b1, 10'h0AB, 10'h3C3, 10'h111, 10'h2EE, 2'b10);
      set_link(1, 1'b0, 10'h3FF, 10'h3FF, 10'h3FF, 10'h3FF, 2'b11);
      set_link(2, 1'b1, 10'h001, 10'h200, 10'h0FF, 10'h300, 2'b01);
      capture("R7 R9", 1'b0);
   endtask

   task automatic t_hold;
      set_link(0, 1'b1, 10'h155, 10'h2AA, 10'h0F0, 10'h30F, 2'b01);
      set_link(1, 1'b1, 10'h3E0, 10'h01F, 10'h18C, 10'h273, 2'b10);
      set_link(2, 1'b1, 10'h222, 10'h111, 10'h3AB, 10'h054, 2'b00);
      capture("R8", 1'b1);
   endtask

   task automatic t_back_to_back;
      set_link(0, 1'b1, 10'h3A5, 10'h05A, 10'h1FF, 10'h200, 2'b11);
      set_link(1, 1'b1, 10'h001, 10'h002, 10'h004, 10'h008, 2'b01);
      set_link(2, 1'b1, 10'h2F0, 10'h10F, 10'h333, 10'h0CC, 2'b10);
      capture("R10", 1'b0);
      check_val("R10", "load with last bit", 64'(word_load), 64'd1);
      set_link(0, 1'b1, 10'h000, 10'h3FF, 10'h000, 10'h3FF, 2'b00);
      set_link(1, 1'b0, 10'h155, 10'h155, 10'h155, 10'h155, 2'b11);
      set_link(2, 1'b1, 10'h2AA, 10'h155, 10'h2AA, 10'h155, 2'b01);
      capture("R10 R4", 1'b0);
   endtask

   initial begin
      t_reset();
      t_period();
      t_invalid_all();
      t_pattern_a();
      t_zero_payload();
      t_mixed_valid();
      t_hold();
      t_back_to_back();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule